// File: doc/BRIEF.md
# Frame Buffer Access Arbiter

This block lets one single-port SRAM frame buffer serve two users. The display side reads the buffer without a break, and a pixel writer updates it now and then. Time is split into repeating four-clock groups. The arbiter does not run its own state machine: it takes its phase straight from the two lowest bits of the horizontal pixel counter.

Each group works in a fixed order:

- Phase 0 puts the display read address on the SRAM and keeps the data bus undriven.
- Phase 1 gives the SRAM a clock to return the data.
- At the end of phase 1 the returned word is loaded into the colour register.
- Phase 2 may slip in one pending pixel write.
- Phase 3 drops the write strobe while the write address and data are held.

The colour register is the only path to the screen. A write can therefore never disturb the picture. The display address takes the upper counter bits, so one stored pixel covers a 4x4 block of screen pixels. The write coordinates use the same layout.

The raster counters and the active-video flag come from a timing generator outside this block. The pixel writer holds its request until it sees the acknowledge.

Top module: `fb_arbiter`

## Requirements
- R1: In phases 0 and 1 (`hcount[1:0]` equal to 0 or 1), `bus_drive` and `sram_we` are low. `sram_addr` carries the display read address.
- R2: The display read address is `{vcount[CNT_W-1:2], hcount[CNT_W-1:2]}`. The row index is in the upper half and the column index is in the lower half.
- R3: On the clock edge that ends phase 1, `pix_color` loads `sram_rdata` if `video_on` is high in that cycle. `pix_color` then holds that value through the following phases 2, 3, 0 and 1.
- R4: If `video_on` is low in the phase-1 cycle, `pix_color` loads zero at that edge.
- R5: In phase 2 with `wr_req` high, the following all hold in that cycle:
  - `sram_addr` equals `{wr_y, wr_x}`;
  - `bus_drive` is high;
  - `sram_we` is high;
  - `sram_wdata` equals `wr_color`.
- R6: In the phase 3 that follows a write, `sram_we` is low. `bus_drive` stays high, and `sram_addr` and `sram_wdata` keep the values from phase 2.
- R7: A `wr_req` that is high only in phases 0, 1 or 3 never raises `sram_we`. The frame buffer ends up holding exactly the writes made in phase 2.
- R8: `wr_ack` is high for exactly one clock: the cycle after a phase 3 that completed a write.
- R9: In a group without a write, phases 2 and 3 keep the display read address on `sram_addr`. `bus_drive` and `sram_we` stay low.
- R10: While `rst` is high, `pix_color` is cleared, `wr_ack` is low and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hcount | input | CNT_W | Horizontal pixel counter; its low two bits are the phase |
| vcount | input | CNT_W | Vertical line counter |
| video_on | input | 1 | High inside the visible raster region |
| wr_req | input | 1 | Pixel write pending; held until `wr_ack` |
| wr_x | input | COORD_W | Column of the pixel to write |
| wr_y | input | COORD_W | Row of the pixel to write |
| wr_color | input | COLOR_W | Colour to write |
| sram_rdata | input | COLOR_W | Read data returned by the SRAM |
| sram_addr | output | 2*COORD_W | SRAM address |
| sram_wdata | output | COLOR_W | Write data for the SRAM data bus |
| bus_drive | output | 1 | Enable for the data-bus driver |
| sram_we | output | 1 | SRAM write strobe |
| pix_color | output | COLOR_W | Registered colour sent to the display |
| wr_ack | output | 1 | One-clock pulse when a write has completed |

## Verification
The bench sweeps full frames, including frames whose active-video shapes cut through the middle of a four-clock group. Writes are requested at unrelated cycles, so requests arrive in every phase.

The bench goes after these corner cases:

- **Capture edge.** If the colour register loads on the wrong edge, it picks up write data or a stale read.
- **Blanking sampled too late.** If the active-video flag is sampled at the wrong time, a coloured pixel leaks into the blanking region.
- **Write held too briefly.** If the address or data is released in phase 3, the write lands on the display read address.
- **Write outside phase 2.** A request that starts in phase 0, 1 or 3 must not write. The bench finds a stray write by comparing the final buffer contents with the set of writes it expected.

// File: rtl/fba_pkg.sv
package fba_pkg;

    // Position inside the four-clock access group.
    typedef enum logic [1:0] {
        PH_ADDR  = 2'd0,
        PH_FETCH = 2'd1,
        PH_SLOT  = 2'd2,
        PH_HOLD  = 2'd3
    } phase_e;

    // One-hot phase flags used to steer the datapath.
    typedef struct packed {
        logic addr;
        logic fetch;
        logic slot;
        logic hold;
    } phase_flags_t;

    function automatic phase_flags_t decode_phase(input phase_e ph);
        phase_flags_t f;
        f.addr  = (ph == PH_ADDR);
        f.fetch = (ph == PH_FETCH);
        f.slot  = (ph == PH_SLOT);
        f.hold  = (ph == PH_HOLD);
        return f;
    endfunction

endpackage

// File: rtl/fba_phase_dec.sv
module fba_phase_dec
    import fba_pkg::*;
(
    input  logic [1:0]   hcount_lsb,
    output phase_e       phase,
    output phase_flags_t flags
);

    always_comb begin
        phase = phase_e'(hcount_lsb);
        flags = decode_phase(phase);
    end

endmodule

// File: rtl/fba_pixel_reg.sv
module fba_pixel_reg #(
    parameter int COLOR_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               capture,
    input  logic               video_on,
    input  logic [COLOR_W-1:0] rdata,
    output logic [COLOR_W-1:0] pix
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pix <= '0;
        end else if (capture) begin
            pix <= video_on ? rdata : '0;
        end
    end

endmodule

// File: rtl/fba_write_slot.sv
module fba_write_slot
    import fba_pkg::*;
#(
    parameter int COORD_W = 8,
    parameter int COLOR_W = 8,
    localparam int ADDR_W = 2 * COORD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  phase_flags_t       flags,
    input  logic               wr_req,
    input  logic [COORD_W-1:0] wr_x,
    input  logic [COORD_W-1:0] wr_y,
    input  logic [COLOR_W-1:0] wr_color,
    output logic               drive,
    output logic               we,
    output logic [ADDR_W-1:0]  waddr,
    output logic [COLOR_W-1:0] wdata,
    output logic               ack
);

    logic               busy_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [COLOR_W-1:0] data_q;
    logic               start;

    assign start = flags.slot & wr_req;

    always_comb begin
        we    = start;
        drive = start | (flags.hold & busy_q);
        waddr = flags.slot ? {wr_y, wr_x} : addr_q;
        wdata = flags.slot ? wr_color : data_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
            ack    <= 1'b0;
        end else begin
            ack <= flags.hold & busy_q;
            if (flags.slot) begin
                busy_q <= wr_req;
                addr_q <= {wr_y, wr_x};
                data_q <= wr_color;
            end else if (flags.hold) begin
                busy_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/fb_arbiter.sv
module fb_arbiter
    import fba_pkg::*;
#(
    parameter int CNT_W   = 10,
    parameter int COORD_W = 8,
    parameter int COLOR_W = 8,
    localparam int ADDR_W = 2 * COORD_W,
    localparam int SUB    = CNT_W - COORD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CNT_W-1:0]   hcount,
    input  logic [CNT_W-1:0]   vcount,
    input  logic               video_on,
    input  logic               wr_req,
    input  logic [COORD_W-1:0] wr_x,
    input  logic [COORD_W-1:0] wr_y,
    input  logic [COLOR_W-1:0] wr_color,
    input  logic [COLOR_W-1:0] sram_rdata,
    output logic [ADDR_W-1:0]  sram_addr,
    output logic [COLOR_W-1:0] sram_wdata,
    output logic               bus_drive,
    output logic               sram_we,
    output logic [COLOR_W-1:0] pix_color,
    output logic               wr_ack
);

    phase_e             phase;
    phase_flags_t       flags;
    logic [ADDR_W-1:0]  rd_addr;
    logic [ADDR_W-1:0]  slot_addr;
    logic [COLOR_W-1:0] slot_data;
    logic               slot_drive;
    logic               slot_we;
    logic               unused_lsb;

    // Block-replicated addressing: each stored pixel spans 2**SUB screen pixels per axis.
    assign rd_addr    = {vcount[CNT_W-1:SUB], hcount[CNT_W-1:SUB]};
    assign unused_lsb = ^{vcount[SUB-1:0], hcount[SUB-1:0], phase};

    fba_phase_dec u_phase (
        .hcount_lsb (hcount[1:0]),
        .phase      (phase),
        .flags      (flags)
    );

    fba_write_slot #(
        .COORD_W (COORD_W),
        .COLOR_W (COLOR_W)
    ) u_wslot (
        .clk      (clk),
        .rst      (rst),
        .flags    (flags),
        .wr_req   (wr_req),
        .wr_x     (wr_x),
        .wr_y     (wr_y),
        .wr_color (wr_color),
        .drive    (slot_drive),
        .we       (slot_we),
        .waddr    (slot_addr),
        .wdata    (slot_data),
        .ack      (wr_ack)
    );

    fba_pixel_reg #(
        .COLOR_W (COLOR_W)
    ) u_pix (
        .clk      (clk),
        .rst      (rst),
        .capture  (flags.fetch),
        .video_on (video_on),
        .rdata    (sram_rdata),
        .pix      (pix_color)
    );

    always_comb begin
        bus_drive  = slot_drive;
        sram_we    = slot_we;
        sram_addr  = slot_drive ? slot_addr : rd_addr;
        sram_wdata = slot_drive ? slot_data : '0;
    end

endmodule

// File: rtl/fb_arbiter_chk.sv
module fb_arbiter_chk #(
    parameter int CNT_W   = 10,
    parameter int COORD_W = 8,
    parameter int COLOR_W = 8,
    localparam int ADDR_W = 2 * COORD_W
) (
    input logic               clk,
    input logic               rst,
    input logic [CNT_W-1:0]   hcount,
    input logic               video_on,
    input logic               wr_req,
    input logic [ADDR_W-1:0]  sram_addr,
    input logic               bus_drive,
    input logic               sram_we,
    input logic [COLOR_W-1:0] pix_color,
    input logic               wr_ack
);

    assert_no_early_drive_R1: assert property (@(posedge clk) disable iff (rst)
        (hcount[1:0] < 2'd2) |-> (!bus_drive && !sram_we));

    assert_pix_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (hcount[1:0] != 2'd1) |=> $stable(pix_color));

    assert_blank_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (hcount[1:0] == 2'd1 && !video_on) |=> (pix_color == '0));

    assert_we_in_slot_R5: assert property (@(posedge clk) disable iff (rst)
        sram_we |-> (hcount[1:0] == 2'd2 && bus_drive && wr_req));

    assert_hold_keeps_addr_R6: assert property (@(posedge clk) disable iff (rst)
        (hcount[1:0] == 2'd3 && bus_drive) |-> (!sram_we && $stable(sram_addr)));

    assert_ack_single_R8: assert property (@(posedge clk) disable iff (rst)
        wr_ack |=> !wr_ack);

    assert_ack_after_hold_R8: assert property (@(posedge clk) disable iff (rst)
        wr_ack |-> $past(hcount[1:0] == 2'd3 && bus_drive));

endmodule

bind fb_arbiter fb_arbiter_chk #(
    .CNT_W   (CNT_W),
    .COORD_W (COORD_W),
    .COLOR_W (COLOR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .hcount    (hcount),
    .video_on  (video_on),
    .wr_req    (wr_req),
    .sram_addr (sram_addr),
    .bus_drive (bus_drive),
    .sram_we   (sram_we),
    .pix_color (pix_color),
    .wr_ack    (wr_ack)
);

// File: tb/fb_arbiter_test.sv
module fb_arbiter_test;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W   = 6;
    localparam int COORD_W = 4;
    localparam int COLOR_W = 8;
    localparam int ADDR_W  = 2 * COORD_W;
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int LINE    = 1 << CNT_W;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [CNT_W-1:0]   hcount = '0;
    logic [CNT_W-1:0]   vcount = '0;
    logic               video_on = 1'b0;
    logic               wr_req = 1'b0;
    logic [COORD_W-1:0] wr_x = '0;
    logic [COORD_W-1:0] wr_y = '0;
    logic [COLOR_W-1:0] wr_color = '0;
    logic [COLOR_W-1:0] sram_rdata;
    logic [ADDR_W-1:0]  sram_addr;
    logic [COLOR_W-1:0] sram_wdata;
    logic               bus_drive;
    logic               sram_we;
    logic [COLOR_W-1:0] pix_color;
    logic               wr_ack;

    logic [COLOR_W-1:0] mem    [DEPTH];
    logic [COLOR_W-1:0] shadow [DEPTH];

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fb_arbiter #(
        .CNT_W   (CNT_W),
        .COORD_W (COORD_W),
        .COLOR_W (COLOR_W)
    ) uut (
        .clk        (clk),
        .rst        (rst),
        .hcount     (hcount),
        .vcount     (vcount),
        .video_on   (video_on),
        .wr_req     (wr_req),
        .wr_x       (wr_x),
        .wr_y       (wr_y),
        .wr_color   (wr_color),
        .sram_rdata (sram_rdata),
        .sram_addr  (sram_addr),
        .sram_wdata (sram_wdata),
        .bus_drive  (bus_drive),
        .sram_we    (sram_we),
        .pix_color  (pix_color),
        .wr_ack     (wr_ack)
    );

    // Asynchronous-read SRAM model; contents seeded arithmetically during reset.
    assign sram_rdata = mem[sram_addr];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= COLOR_W'(i * 37 + 11);
        end else if (sram_we) begin
            mem[sram_addr] <= sram_wdata;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    function automatic logic active_shape(int f, int h, int v);
        case (f)
            0:       return 1'b1;
            1:       return (h < 45) && (v < 41);
            default: return ((h ^ v) & 5) != 0;
        endcase
    endfunction

    initial begin
        logic [COLOR_W-1:0] exp_pix;
        logic               exp_ack;
        logic               busy;
        logic [ADDR_W-1:0]  haddr;
        logic [COLOR_W-1:0] hdata;
        int                 cyc;
        int                 lcg;

        exp_pix = '0;
        exp_ack = 1'b0;
        busy    = 1'b0;
        haddr   = '0;
        hdata   = '0;
        cyc     = 0;
        lcg     = 7;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check("R10 pix after reset", pix_color, 0);
        check("R10 ack after reset", wr_ack, 0);
        check("R10 we after reset", sram_we, 0);
        check("R10 drive after reset", bus_drive, 0);
        for (int i = 0; i < DEPTH; i++) shadow[i] = COLOR_W'(i * 37 + 11);

        for (int f = 0; f < 3; f++) begin
            for (int v = 0; v < LINE; v++) begin
                for (int h = 0; h < LINE; h++) begin
                    logic [1:0]        ph;
                    logic [ADDR_W-1:0] rd;
                    logic              von;

                    @(negedge clk);
                    // Registered outputs after the previous edge.
                    check("R3/R4 pix_color", pix_color, exp_pix);
                    check("R8 wr_ack", wr_ack, exp_ack);

                    // Requester: drop on ack, raise new requests at unrelated cycles.
                    if (wr_ack) begin
                        wr_req = 1'b0;
                    end else if (!wr_req && (cyc % 29 == 3 || cyc % 53 == 17)) begin
                        lcg      = (lcg * 1103 + 12345) & 32'h7fff_ffff;
                        wr_req   = 1'b1;
                        wr_x     = COORD_W'(lcg >> 3);
                        wr_y     = COORD_W'(lcg >> 9);
                        wr_color = COLOR_W'(lcg >> 15);
                    end

                    von      = active_shape(f, h, v);
                    hcount   = CNT_W'(h);
                    vcount   = CNT_W'(v);
                    video_on = von;
                    #1;

                    ph = 2'(h);
                    rd = {vcount[CNT_W-1:2], hcount[CNT_W-1:2]};
                    case (ph)
                        2'd0, 2'd1: begin
                            check("R1/R2 read addr", sram_addr, rd);
                            check("R1 drive off", bus_drive, 0);
                            check("R1/R7 we off", sram_we, 0);
                        end
                        2'd2: begin
                            if (wr_req) begin
                                check("R5 write addr", sram_addr, {wr_y, wr_x});
                                check("R5 drive on", bus_drive, 1);
                                check("R5 we on", sram_we, 1);
                                check("R5 wdata", sram_wdata, wr_color);
                            end else begin
                                check("R9 slot addr", sram_addr, rd);
                                check("R9 slot drive", bus_drive, 0);
                                check("R9 slot we", sram_we, 0);
                            end
                        end
                        default: begin
                            if (busy) begin
                                check("R6 hold addr", sram_addr, haddr);
                                check("R6 hold wdata", sram_wdata, hdata);
                                check("R6 hold drive", bus_drive, 1);
                                check("R6 hold we low", sram_we, 0);
                            end else begin
                                check("R9 hold addr", sram_addr, rd);
                                check("R9 hold drive", bus_drive, 0);
                                check("R7 hold we", sram_we, 0);
                            end
                        end
                    endcase

                    // Model state for the coming edge.
                    if (ph == 2'd1) exp_pix = von ? mem[rd] : '0;
                    exp_ack = (ph == 2'd3) && busy;
                    if (ph == 2'd2) begin
                        busy  = wr_req;
                        haddr = {wr_y, wr_x};
                        hdata = wr_color;
                        if (wr_req) shadow[{wr_y, wr_x}] = wr_color;
                    end else if (ph == 2'd3) begin
                        busy = 1'b0;
                    end
                    cyc++;
                end
            end
        end

        @(negedge clk);
        // R7: buffer holds exactly the phase-2 writes
        for (int i = 0; i < DEPTH; i++) check("R7 buffer contents", mem[i], shadow[i]);
        finish_run();
    end

endmodule